// File: doc/BRIEF.md
# Expansion Bus Device Select Controller

This block sits between an 8-bit CPU bus and a set of cooperating expansion peripherals. It decodes three 256-byte pages of the I/O space. The select page contains a device-select register that turns on exactly one peripheral's option ROM, or none, in a shared overlay window. Two further pages act as optional general-purpose RAM. When no peripheral drives the data bus, a read of the select register returns the interrupt flags of all peripherals combined into one byte. Software can then find out which device raised the shared interrupt line.

The block also drives a flag for the memory map that says whether the built-in math ROM at 0xD800–0xDFFF is visible. A newly written selection that no peripheral acknowledges makes the math ROM visible again. An acknowledged selection hides it. A takeover input hands all three pages to a single external device, which bypasses the register and the RAM.

Writes take effect on the rising clock edge. Read data is combinational from the address and the current state.

Top module: `xbus_select_ctrl`

## Requirements
- R1: After reset, `dev_select` is 0x00 and `math_rom_on` is 1. Interrupt status read at 0xD1FF is 0x00 until the first clock edge after reset, whatever `dev_irq` is.
- R2: A write to 0xD1FF with data 0x00 or with exactly one bit set, differing from the current `dev_select`, loads `dev_select` at the next rising edge.
- R3: A write to 0xD1FF whose data has two or more bits set leaves `dev_select` and `math_rom_on` unchanged.
- R4: A write to 0xD1FF of the value already in `dev_select` changes neither `dev_select` nor `math_rom_on`, whatever `dev_ack` is.
- R5: On an accepted new selection (R2), `math_rom_on` becomes 1 if `dev_ack` is all zero in the write cycle, and 0 otherwise.
- R6: A read of 0xD1FF with `dev_claim` all zero returns the `dev_irq` vector sampled at the previous rising edge. Bit n is device n, and bits at or above NUM_DEV read as 0.
- R7: A read anywhere in page 0xD1 with any `dev_claim` bit set returns `dev_rdata`. An unclaimed read of page 0xD1 at any address other than 0xD1FF returns 0xFF. A write to page 0xD1 at any address other than 0xD1FF leaves `dev_select` unchanged.
- R8: With `ram_en` = 1, pages 0xD6 and 0xD7 are 512 distinct bytes. A write stores `wdata` at the next edge, and a read returns the stored byte.
- R9: With `ram_en` = 0, reads of pages 0xD6/0xD7 return 0xFF and writes are dropped, so the earlier contents read back once `ram_en` returns to 1.
- R10: With `takeover` = 1, any access to pages 0xD1, 0xD6 or 0xD7 returns `ext_rdata` and raises `ext_sel` while `rd_en` or `wr_en` is high. Writes in that state change neither `dev_select`, `math_rom_on` nor RAM.
- R11: Accesses outside pages 0xD1, 0xD6 and 0xD7 read 0xFF, never raise `ext_sel`, and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (16) | CPU address |
| wdata | input | DATA_W (8) | CPU write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rdata | output | DATA_W (8) | Read data, combinational |
| dev_claim | input | NUM_DEV (8) | Per-device claim of a select-page read |
| dev_rdata | input | DATA_W (8) | Data from the claiming device |
| dev_ack | input | NUM_DEV (8) | Per-device acknowledge of a new selection |
| dev_irq | input | NUM_DEV (8) | Per-device interrupt request level |
| ram_en | input | 1 | Enables the RAM pages |
| takeover | input | 1 | Routes all three pages to one external device |
| ext_rdata | input | DATA_W (8) | Read data from the takeover device |
| ext_sel | output | 1 | Access is routed to the takeover device |
| dev_select | output | DATA_W (8) | Current one-hot device select |
| math_rom_on | output | 1 | Math ROM overlay visible |

## Verification
The bench builds the block with its default parameters: eight devices (so every bit of the select byte has a device behind it), two RAM pages, and the RAM variant present. Because NUM_DEV equals the data width, the interrupt byte has no padding bits, and the reachable invalid select values include the mixed patterns 0x03, 0x81 and 0xFF. With two RAM pages, the same offset in 0xD6 and 0xD7 can be shown to land in separate bytes. The reference model follows selection, overlay, interrupt sampling and RAM contents every clock and flags any divergence on the ports.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

   typedef enum logic [1:0] {
      XR_NONE = 2'd0,
      XR_SEL  = 2'd1,
      XR_RAM  = 2'd2
   } xbs_region_e;

   typedef struct packed {
      xbs_region_e region;
      logic        sel_reg;
      logic        takeover_hit;
   } xbs_decode_t;

endpackage

// File: rtl/xbs_decode.sv
module xbs_decode
   import xbs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SEL_PAGE   = 'hD1,
   parameter int SEL_OFFSET = 'hFF,
   parameter int RAM_PAGE   = 'hD6,
   parameter int RAM_PAGES  = 2,
   localparam int OFF_W     = 8,
   localparam int PAGE_W    = ADDR_W - OFF_W,
   localparam int IDX_W     = (RAM_PAGES > 1) ? $clog2(RAM_PAGES) : 1,
   localparam int RAM_AW    = OFF_W + IDX_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              takeover,
   output xbs_decode_t       dec,
   output logic [RAM_AW-1:0] ram_addr
);

   localparam logic [PAGE_W-1:0] SEL_PG = PAGE_W'(SEL_PAGE);
   localparam logic [OFF_W-1:0]  SEL_OF = OFF_W'(SEL_OFFSET);
   localparam logic [PAGE_W-1:0] RAM_LO = PAGE_W'(RAM_PAGE);
   localparam logic [PAGE_W-1:0] RAM_HI = PAGE_W'(RAM_PAGE + RAM_PAGES - 1);

   if (ADDR_W <= OFF_W) begin : g_bad_addr_w
      $error("xbs_decode: ADDR_W must exceed the page offset width");
   end
   if (RAM_PAGES < 1) begin : g_bad_pages
      $error("xbs_decode: RAM_PAGES must be at least 1");
   end

   logic [PAGE_W-1:0] page;
   logic [OFF_W-1:0]  offset;
   logic [PAGE_W-1:0] pg_rel;
   logic              in_sel;
   logic              in_ram;
   logic              unused_rel;

   assign page   = addr[ADDR_W-1:OFF_W];
   assign offset = addr[OFF_W-1:0];
   assign pg_rel = page - RAM_LO;
   assign unused_rel = ^pg_rel;

   assign in_sel = (page == SEL_PG);
   assign in_ram = (page >= RAM_LO) && (page <= RAM_HI);

   always_comb begin
      dec = '0;
      if (in_sel) begin
         dec.region = XR_SEL;
      end else if (in_ram) begin
         dec.region = XR_RAM;
      end else begin
         dec.region = XR_NONE;
      end
      dec.sel_reg      = in_sel && (offset == SEL_OF);
      dec.takeover_hit = takeover && (in_sel || in_ram);
   end

   assign ram_addr = {pg_rel[IDX_W-1:0], offset};

endmodule

// File: rtl/xbs_select_latch.sv
module xbs_select_latch #(
   parameter int DATA_W  = 8,
   parameter int NUM_DEV = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_we,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_DEV-1:0] dev_ack,
   input  logic [NUM_DEV-1:0] dev_irq,
   output logic [DATA_W-1:0]  sel_q,
   output logic               rom_on_q,
   output logic [NUM_DEV-1:0] irq_q
);

   if (NUM_DEV < 1 || NUM_DEV > DATA_W) begin : g_bad_dev
      $error("xbs_select_latch: NUM_DEV must lie in 1..DATA_W");
   end

   logic shape_ok;
   logic differs;
   logic take;
   logic any_ack;

   assign shape_ok = ($countones(wdata) <= 1);
   assign differs  = (wdata != sel_q);
   assign take     = sel_we && shape_ok && differs;
   assign any_ack  = |dev_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         rom_on_q <= 1'b1;
         irq_q    <= '0;
      end else begin
         irq_q <= dev_irq;
         if (take) begin
            sel_q    <= wdata;
            rom_on_q <= ~any_ack;
         end
      end
   end

endmodule

// File: rtl/xbs_page_ram.sv
module xbs_page_ram #(
   parameter bit HAS_RAM = 1'b1,
   parameter int AW      = 9,
   parameter int DATA_W  = 8,
   localparam int DEPTH  = 1 << AW
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   if (HAS_RAM) begin : g_ram
      logic [DATA_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we) begin
            mem[addr] <= wdata;
         end
      end

      assign rdata = mem[addr];
   end else begin : g_no_ram
      logic unused_ram;
      assign unused_ram = ^{clk, we, addr, wdata};
      assign rdata      = '1;
   end

endmodule

// File: rtl/xbus_select_ctrl.sv
module xbus_select_ctrl
   import xbs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int NUM_DEV    = 8,
   parameter int SEL_PAGE   = 'hD1,
   parameter int SEL_OFFSET = 'hFF,
   parameter int RAM_PAGE   = 'hD6,
   parameter int RAM_PAGES  = 2,
   parameter bit HAS_RAM    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               rd_en,
   input  logic               wr_en,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_DEV-1:0] dev_claim,
   input  logic [DATA_W-1:0]  dev_rdata,
   input  logic [NUM_DEV-1:0] dev_ack,
   input  logic [NUM_DEV-1:0] dev_irq,
   input  logic               ram_en,
   input  logic               takeover,
   input  logic [DATA_W-1:0]  ext_rdata,
   output logic               ext_sel,
   output logic [DATA_W-1:0]  dev_select,
   output logic               math_rom_on
);

   localparam int OFF_W  = 8;
   localparam int IDX_W  = (RAM_PAGES > 1) ? $clog2(RAM_PAGES) : 1;
   localparam int RAM_AW = OFF_W + IDX_W;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("xbus_select_ctrl: the select byte is 8 bits wide");
   end

   xbs_decode_t         dec;
   logic [RAM_AW-1:0]   ram_addr;
   logic [DATA_W-1:0]   ram_rdata;
   logic [NUM_DEV-1:0]  irq_q;
   logic [DATA_W-1:0]   irq_word;
   logic                sel_we;
   logic                ram_we;
   logic                local_wr;

   xbs_decode #(
      .ADDR_W     (ADDR_W),
      .SEL_PAGE   (SEL_PAGE),
      .SEL_OFFSET (SEL_OFFSET),
      .RAM_PAGE   (RAM_PAGE),
      .RAM_PAGES  (RAM_PAGES)
   ) u_decode (
      .addr     (addr),
      .takeover (takeover),
      .dec      (dec),
      .ram_addr (ram_addr)
   );

   assign local_wr = wr_en && !dec.takeover_hit;
   assign sel_we   = local_wr && dec.sel_reg;
   assign ram_we   = local_wr && ram_en && (dec.region == XR_RAM);

   xbs_select_latch #(
      .DATA_W  (DATA_W),
      .NUM_DEV (NUM_DEV)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_we   (sel_we),
      .wdata    (wdata),
      .dev_ack  (dev_ack),
      .dev_irq  (dev_irq),
      .sel_q    (dev_select),
      .rom_on_q (math_rom_on),
      .irq_q    (irq_q)
   );

   xbs_page_ram #(
      .HAS_RAM (HAS_RAM),
      .AW      (RAM_AW),
      .DATA_W  (DATA_W)
   ) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (wdata),
      .rdata (ram_rdata)
   );

   if (NUM_DEV == DATA_W) begin : g_irq_full
      assign irq_word = irq_q;
   end else begin : g_irq_pad
      assign irq_word = {{(DATA_W - NUM_DEV){1'b0}}, irq_q};
   end

   always_comb begin
      rdata = '1;
      if (dec.takeover_hit) begin
         rdata = ext_rdata;
      end else begin
         case (dec.region)
            XR_SEL: begin
               if (|dev_claim) begin
                  rdata = dev_rdata;
               end else if (dec.sel_reg) begin
                  rdata = irq_word;
               end
            end
            XR_RAM: begin
               if (ram_en) begin
                  rdata = ram_rdata;
               end
            end
            default: rdata = '1;
         endcase
      end
   end

   assign ext_sel = dec.takeover_hit && (rd_en || wr_en);

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int NUM_DEV    = 8,
   parameter int SEL_PAGE   = 'hD1,
   parameter int SEL_OFFSET = 'hFF,
   parameter int RAM_PAGE   = 'hD6,
   parameter int RAM_PAGES  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr,
   input logic [DATA_W-1:0]  wdata,
   input logic               rd_en,
   input logic               wr_en,
   input logic [DATA_W-1:0]  rdata,
   input logic [NUM_DEV-1:0] dev_claim,
   input logic [NUM_DEV-1:0] dev_ack,
   input logic               ram_en,
   input logic               takeover,
   input logic               ext_sel,
   input logic [DATA_W-1:0]  dev_select,
   input logic               math_rom_on
);

   localparam int OFF_W  = 8;
   localparam int PAGE_W = ADDR_W - OFF_W;

   logic [PAGE_W-1:0] pg;
   logic              pg_sel;
   logic              pg_ram;
   logic              at_reg;

   assign pg     = addr[ADDR_W-1:OFF_W];
   assign pg_sel = (int'(pg) == SEL_PAGE);
   assign pg_ram = (int'(pg) >= RAM_PAGE) && (int'(pg) < RAM_PAGE + RAM_PAGES);
   assign at_reg = pg_sel && (int'(addr[OFF_W-1:0]) == SEL_OFFSET);

   a_r2_select_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_select));

   a_r3_bad_value_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !takeover && at_reg && $countones(wdata) > 1)
      |=> ($stable(dev_select) && $stable(math_rom_on)));

   a_r4_same_value_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && at_reg && wdata == dev_select)
      |=> ($stable(dev_select) && $stable(math_rom_on)));

   a_r5_overlay_back: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !takeover && at_reg && $countones(wdata) <= 1
       && wdata != dev_select && dev_ack == '0)
      |=> math_rom_on);

   a_r5_overlay_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !takeover && at_reg && $countones(wdata) <= 1
       && wdata != dev_select && dev_ack != '0)
      |=> !math_rom_on);

   a_r7_unclaimed_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (!takeover && pg_sel && !at_reg && dev_claim == '0) |-> (rdata == '1));

   a_r9_ram_off_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (!takeover && pg_ram && !ram_en) |-> (rdata == '1));

   a_r10_takeover_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      takeover |=> ($stable(dev_select) && $stable(math_rom_on)));

   a_r11_ext_sel_scope: assert property (@(posedge clk) disable iff (!rst_n)
      ext_sel |-> (takeover && (pg_sel || pg_ram) && (rd_en || wr_en)));

endmodule

bind xbus_select_ctrl xbs_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NUM_DEV    (NUM_DEV),
   .SEL_PAGE   (SEL_PAGE),
   .SEL_OFFSET (SEL_OFFSET),
   .RAM_PAGE   (RAM_PAGE),
   .RAM_PAGES  (RAM_PAGES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr        (addr),
   .wdata       (wdata),
   .rd_en       (rd_en),
   .wr_en       (wr_en),
   .rdata       (rdata),
   .dev_claim   (dev_claim),
   .dev_ack     (dev_ack),
   .ram_en      (ram_en),
   .takeover    (takeover),
   .ext_sel     (ext_sel),
   .dev_select  (dev_select),
   .math_rom_on (math_rom_on)
);

// File: tb/xbus_select_ctrl_test.sv
module xbus_select_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [7:0]  wdata = 8'h00;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  rdata;
   logic [7:0]  dev_claim = 8'h00;
   logic [7:0]  dev_rdata = 8'h00;
   logic [7:0]  dev_ack = 8'h00;
   logic [7:0]  dev_irq = 8'h00;
   logic        ram_en = 1'b0;
   logic        takeover = 1'b0;
   logic [7:0]  ext_rdata = 8'h00;
   logic        ext_sel;
   logic [7:0]  dev_select;
   logic        math_rom_on;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_sel = 8'h00;
   logic       m_rom = 1'b1;
   logic [7:0] m_irq = 8'h00;
   logic [7:0] m_mem [int];

   always #10 clk = ~clk;

   xbus_select_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr),
      .wdata       (wdata),
      .rd_en       (rd_en),
      .wr_en       (wr_en),
      .rdata       (rdata),
      .dev_claim   (dev_claim),
      .dev_rdata   (dev_rdata),
      .dev_ack     (dev_ack),
      .dev_irq     (dev_irq),
      .ram_en      (ram_en),
      .takeover    (takeover),
      .ext_rdata   (ext_rdata),
      .ext_sel     (ext_sel),
      .dev_select  (dev_select),
      .math_rom_on (math_rom_on)
   );

   function automatic int bits_set(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic bit is_sel_page(input logic [15:0] a);
      return a[15:8] == 8'hD1;
   endfunction

   function automatic bit is_ram_page(input logic [15:0] a);
      return a[15:8] == 8'hD6 || a[15:8] == 8'hD7;
   endfunction

   task automatic check8(input string tag, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   // One bus cycle: inputs already driven after a falling edge
   task automatic step(input string tag);
      bit         win;
      bit         known;
      logic [7:0] exp_rd;
      logic [7:0] n_sel;
      logic       n_rom;
      #2;
      win   = is_sel_page(addr) || is_ram_page(addr);
      known = 1'b1;
      exp_rd = 8'hFF;
      if (takeover && win) begin
         exp_rd = ext_rdata;
      end else if (is_sel_page(addr)) begin
         if (dev_claim != 8'h00) exp_rd = dev_rdata;
         else if (addr == 16'hD1FF) exp_rd = m_irq;
      end else if (is_ram_page(addr) && ram_en) begin
         if (m_mem.exists(int'(addr))) exp_rd = m_mem[int'(addr)];
         else known = 1'b0;
      end
      if (known) check8(tag, "rdata", rdata, exp_rd);
      check8(tag, "dev_select", dev_select, m_sel);
      check8(tag, "math_rom_on", {7'd0, math_rom_on}, {7'd0, m_rom});
      check8(tag, "ext_sel", {7'd0, ext_sel},
             {7'd0, takeover && win && (rd_en || wr_en)});
      n_sel = m_sel;
      n_rom = m_rom;
      if (!(takeover && win) && wr_en) begin
         if (addr == 16'hD1FF && bits_set(wdata) <= 1 && wdata != m_sel) begin
            n_sel = wdata;
            n_rom = (dev_ack == 8'h00);
         end
         if (is_ram_page(addr) && ram_en) m_mem[int'(addr)] = wdata;
      end
      @(posedge clk);
      m_sel = n_sel;
      m_rom = n_rom;
      m_irq = dev_irq;
      @(negedge clk);
   endtask

   task automatic rd(input string tag, input logic [15:0] a);
      addr = a; rd_en = 1'b1; wr_en = 1'b0;
      step(tag);
      rd_en = 1'b0;
   endtask

   task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
      step(tag);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      dev_irq = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, interrupt flags cleared despite active requests
      rd("R1", 16'hD1FF);
      dev_irq = 8'h05;
      rd("R6", 16'hD1FF);
      dev_irq = 8'h80;
      rd("R6", 16'hD1FF);
      rd("R6", 16'hD1FF);
      dev_irq = 8'h00;
      rd("R6", 16'hD1FF);

      // R2/R5: selections with and without acknowledge
      wr("R2", 16'hD1FF, 8'h04);
      rd("R2", 16'hD1FF);
      dev_ack = 8'h10;
      wr("R5", 16'hD1FF, 8'h10);
      dev_ack = 8'h00;
      rd("R5", 16'hD1FF);
      wr("R5", 16'hD1FF, 8'h00);
      rd("R5", 16'hD1FF);

      // R3: multi-bit values ignored
      dev_ack = 8'h01;
      wr("R3", 16'hD1FF, 8'h03);
      wr("R3", 16'hD1FF, 8'hFF);
      wr("R3", 16'hD1FF, 8'h81);
      dev_ack = 8'h00;
      rd("R3", 16'hD1FF);

      // R4: repeat of the held value keeps the hidden overlay hidden
      dev_ack = 8'h20;
      wr("R4", 16'hD1FF, 8'h20);
      dev_ack = 8'h00;
      wr("R4", 16'hD1FF, 8'h20);
      rd("R4", 16'hD1FF);
      wr("R2", 16'hD1FF, 8'h80);
      rd("R2", 16'hD1FF);

      // R7: claimed and unclaimed select-page reads, other writes
      dev_claim = 8'h02; dev_rdata = 8'h3C;
      rd("R7", 16'hD1FF);
      dev_claim = 8'h80; dev_rdata = 8'hC3;
      rd("R7", 16'hD1FE);
      dev_claim = 8'h00;
      rd("R7", 16'hD100);
      wr("R7", 16'hD180, 8'h01);
      rd("R7", 16'hD1FF);

      // R8: RAM pages
      ram_en = 1'b1;
      wr("R8", 16'hD600, 8'hA5);
      wr("R8", 16'hD7FF, 8'h3C);
      wr("R8", 16'hD700, 8'h5A);
      rd("R8", 16'hD600);
      rd("R8", 16'hD700);
      rd("R8", 16'hD7FF);

      // R9: disabled RAM
      ram_en = 1'b0;
      rd("R9", 16'hD600);
      wr("R9", 16'hD600, 8'h11);
      ram_en = 1'b1;
      rd("R9", 16'hD600);

      // R10: takeover
      takeover = 1'b1; ext_rdata = 8'h6E;
      rd("R10", 16'hD1FF);
      rd("R10", 16'hD7FF);
      wr("R10", 16'hD1FF, 8'h01);
      wr("R10", 16'hD600, 8'h77);
      addr = 16'hD655; step("R10");
      rd("R11", 16'hC000);
      takeover = 1'b0;
      rd("R10", 16'hD600);
      rd("R10", 16'hD1FF);

      // R11: outside the window
      wr("R11", 16'h1234, 8'h02);
      wr("R11", 16'hD5FF, 8'h01);
      rd("R11", 16'hD500);
      rd("R11", 16'hD800);
      rd("R11", 16'hD1FF);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule